// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the A and B channels of an incremental encoder into a 16-bit position count. Each channel edge, rising or falling, moves the count by one step. The phase relation between the channels sets the direction. Each input, including an index input, first passes through a two-flop synchronizer. It then passes through a glitch filter. The filter samples on a tick from a shared clock divider, and the divide ratio can be selected.

The count wraps at a programmable maximum in both directions. A synchronous clear sets it to zero. If both channels change in the same filtered sample, the step is illegal. The block then raises a sticky error flag and leaves the count alone. A direction output reports the sense of the last valid step.

A software reader can take a snapshot of the count. It then reads the snapshot as two halves through a narrow port. Both halves therefore always come from the same count value, even while the encoder keeps moving.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, pos_o is 0, dir_o is 0, err_o is 0 and idx_o is 0.
- R2: The channel state is written {a,b}. The up sequence is 00, 10, 11, 01, 00. Each single-channel change along it adds one to pos_o.
- R3: Each single-channel change that runs the up sequence backwards subtracts one from pos_o.
- R4: An up step taken at max_cnt_i gives 0. A down step taken at 0 gives max_cnt_i.
- R5: A filtered input changes only when the synchronized input has shown the new level on 3 consecutive sample ticks. A pulse shorter than that has no effect on pos_o.
- R6: A sample tick occurs once every div_i+1 clock cycles.
- R7: With div_i = 0, a valid channel change driven between two clock edges shows on pos_o after the 6th following rising edge, and not after the 5th.
- R8: If A and B change in the same filtered sample, err_o is set and pos_o is unchanged. err_o stays set until err_clr_i is pulsed.
- R9: dir_o is 1 after a counted up step and 0 after a counted down step.
- R10: clr_i clears pos_o to 0 on the next edge. It takes precedence over a step in the same cycle.
- R11: snap_i captures pos_o. rd_half_o returns the upper half of the capture when rd_hi_i is 1 and the lower half otherwise. The capture stays unchanged until the next snap_i.
- R12: While en_i is 0, steps leave pos_o and dir_o unchanged. Phase tracking continues, so after re-enable only new steps count.
- R13: idx_o is the filtered index input and follows the same filter rule as A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder channel A, asynchronous |
| b_i | input | 1 | Encoder channel B, asynchronous |
| idx_i | input | 1 | Encoder index, asynchronous |
| div_i | input | DIV_W | Sample tick divider; tick every div_i+1 cycles |
| en_i | input | 1 | Counting enable |
| max_cnt_i | input | CNT_W | Wrap limit of the count |
| clr_i | input | 1 | Synchronous clear of the count |
| err_clr_i | input | 1 | Clears the illegal-transition flag |
| snap_i | input | 1 | Capture the count for reading |
| rd_hi_i | input | 1 | Selects the upper half of the capture |
| pos_o | output | CNT_W | Live position count |
| rd_half_o | output | CNT_W/2 | Selected half of the captured count |
| dir_o | output | 1 | Sense of the last counted step, 1 = up |
| err_o | output | 1 | Sticky illegal-transition flag |
| idx_o | output | 1 | Filtered index |

## Verification
With div_i at 0, an input change reaches the filter output on the 5th rising edge: two synchronizer stages, then three samples. The count and direction change one edge later, on the 6th. The latency scenario samples at the falling edge after the 5th and after the 6th rising edge. The clear-precedence scenario raises clr_i exactly for that 6th edge.

Other scenarios drive an input at a falling edge and wait a settle window of 3·(div_i+1)+8 cycles before sampling. This window covers every divider phase. The divider scenario uses a pulse of 8 cycles at a tick period of 4. That pulse spans exactly two ticks whatever the phase, so it must be rejected. Snapshot and clear results are sampled at the falling edge after the single capturing edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_ERR  = 2'd3
  } step_e;

  localparam int unsigned IN_A   = 0;
  localparam int unsigned IN_B   = 1;
  localparam int unsigned IN_IDX = 2;
  localparam int unsigned N_IN   = 3;
endpackage

// File: rtl/qenc_sample_div.sv
module qenc_sample_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the tick period bounded when div_i shrinks mid-count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qenc_in_filter.sv
module qenc_in_filter #(
  parameter int unsigned FILT_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  logic              sync1_q, sync2_q;
  logic [FILT_N-1:0] hist_q;
  logic [FILT_N-1:0] hist_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
    end
  end

  assign hist_d = {hist_q[FILT_N-2:0], sync2_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_o <= 1'b0;
    end else if (tick_i) begin
      hist_q <= hist_d;
      if (&hist_d)       filt_o <= 1'b1;
      else if (~|hist_d) filt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  a_i,
  input  logic  b_i,
  output step_e step_o
);
  logic a_q, b_q;
  logic a_chg, b_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg = a_i ^ a_q;
  assign b_chg = b_i ^ b_q;

  always_comb begin
    if (a_chg && b_chg)      step_o = STEP_ERR;
    else if (a_chg || b_chg) step_o = (a_i ^ b_q) ? STEP_UP : STEP_DN;
    else                     step_o = STEP_NONE;
  end
endmodule

// File: rtl/qenc_pos_reg.sv
module qenc_pos_reg
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  step_e            step_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] pos_d;

  always_comb begin
    pos_d = pos_o;
    if (clr_i) begin
      pos_d = '0;
    end else if (en_i) begin
      unique case (step_i)
        STEP_UP: pos_d = (pos_o >= max_i) ? '0 : pos_o + 1'b1;
        STEP_DN: pos_d = (pos_o == '0) ? max_i : pos_o - 1'b1;
        default: pos_d = pos_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      snap_o <= '0;
    end else begin
      pos_o <= pos_d;
      if (snap_i) snap_o <= pos_o;
    end
  end
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned FILT_N = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_i,
  input  logic               b_i,
  input  logic               idx_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               en_i,
  input  logic [CNT_W-1:0]   max_cnt_i,
  input  logic               clr_i,
  input  logic               err_clr_i,
  input  logic               snap_i,
  input  logic               rd_hi_i,
  output logic [CNT_W-1:0]   pos_o,
  output logic [CNT_W/2-1:0] rd_half_o,
  output logic               dir_o,
  output logic               err_o,
  output logic               idx_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic             tick;
  logic [N_IN-1:0]  raw;
  logic [N_IN-1:0]  filt;
  step_e            step;
  logic [CNT_W-1:0] snap;

  assign raw[IN_A]   = a_i;
  assign raw[IN_B]   = b_i;
  assign raw[IN_IDX] = idx_i;

  qenc_sample_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .tick_o (tick)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_filt
    qenc_in_filter #(.FILT_N(FILT_N)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .raw_i  (raw[g]),
      .filt_o (filt[g])
    );
  end

  qenc_step_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (filt[IN_A]),
    .b_i    (filt[IN_B]),
    .step_o (step)
  );

  qenc_pos_reg #(.CNT_W(CNT_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .step_i (step),
    .max_i  (max_cnt_i),
    .snap_i (snap_i),
    .pos_o  (pos_o),
    .snap_o (snap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      if (step == STEP_ERR) err_o <= 1'b1;
      else if (err_clr_i)   err_o <= 1'b0;
      if (en_i && !clr_i) begin
        if (step == STEP_UP)      dir_o <= 1'b1;
        else if (step == STEP_DN) dir_o <= 1'b0;
      end
    end
  end

  assign rd_half_o = rd_hi_i ? snap[CNT_W-1 -: HALF_W] : snap[HALF_W-1:0];
  assign idx_o     = filt[IN_IDX];
endmodule

// File: rtl/qenc_pos_counter_chk.sv
module qenc_pos_counter_chk
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               en_i,
  input logic               err_clr_i,
  input logic               snap_i,
  input logic               rd_hi_i,
  input logic [CNT_W-1:0]   max_cnt_i,
  input logic [CNT_W-1:0]   pos_o,
  input logic [CNT_W/2-1:0] rd_half_o,
  input logic               dir_o,
  input logic               err_o,
  input step_e              step
);
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pos_o == '0); // R10

  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && step == STEP_UP && pos_o == max_cnt_i) |=> pos_o == '0); // R4

  AST_WRAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && step == STEP_DN && pos_o == '0) |=> pos_o == $past(max_cnt_i)); // R4

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step == STEP_ERR) |=> ($stable(pos_o) && err_o)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o); // R8

  AST_DIR_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && step == STEP_UP) |=> dir_o); // R9

  AST_DIR_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && step == STEP_DN) |=> !dir_o); // R9

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> ($stable(pos_o) && $stable(dir_o))); // R12

  AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> (rd_hi_i != $past(rd_hi_i)) || $stable(rd_half_o)); // R11
endmodule

bind qenc_pos_counter qenc_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .en_i      (en_i),
  .err_clr_i (err_clr_i),
  .snap_i    (snap_i),
  .rd_hi_i   (rd_hi_i),
  .max_cnt_i (max_cnt_i),
  .pos_o     (pos_o),
  .rd_half_o (rd_half_o),
  .dir_o     (dir_o),
  .err_o     (err_o),
  .step      (step)
);

// File: tb/qenc_pos_counter_tb.sv
module qenc_pos_counter_tb;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             a = 1'b0, b = 1'b0, idx = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             en = 1'b1;
  logic [CNT_W-1:0] max_cnt = 16'hFFFF;
  logic             clr = 1'b0, err_clr = 1'b0, snap = 1'b0, rd_hi = 1'b0;
  logic [CNT_W-1:0] pos;
  logic [7:0]       rd_half;
  logic             dir, err, idx_f;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  qenc_pos_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .idx_i(idx),
    .div_i(div), .en_i(en), .max_cnt_i(max_cnt), .clr_i(clr),
    .err_clr_i(err_clr), .snap_i(snap), .rd_hi_i(rd_hi),
    .pos_o(pos), .rd_half_o(rd_half), .dir_o(dir), .err_o(err), .idx_o(idx_f)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3 * (int'(div) + 1) + 8) @(negedge clk);
  endtask

  // Next {a,b} along the up sequence 00,10,11,01
  function automatic logic [1:0] nxt(input logic [1:0] ab, input logic up);
    logic [1:0] r;
    if (up)
      case (ab) 2'b00: r = 2'b10; 2'b10: r = 2'b11; 2'b11: r = 2'b01; default: r = 2'b00; endcase
    else
      case (ab) 2'b00: r = 2'b01; 2'b01: r = 2'b11; 2'b11: r = 2'b10; default: r = 2'b00; endcase
    return r;
  endfunction

  task automatic step(input logic up);
    {a, b} = nxt({a, b}, up);
    settle();
  endtask

  task automatic t_reset();
    chk("R1 pos", pos, 0);
    chk("R1 dir", dir, 0);
    chk("R1 err", err, 0);
    chk("R1 idx", idx_f, 0);
  endtask

  task automatic t_forward();
    for (int i = 1; i <= 4; i++) begin
      step(1'b1);
      chk("R2 up count", pos, i);
    end
    chk("R9 dir up", dir, 1);
  endtask

  task automatic t_reverse();
    for (int i = 3; i >= 0; i--) begin
      step(1'b0);
      chk("R3 down count", pos, i);
    end
    chk("R9 dir down", dir, 0);
  endtask

  task automatic t_wrap();
    step(1'b0);
    chk("R4 wrap down", pos, 16'hFFFF);
    step(1'b1);
    chk("R4 wrap up full", pos, 0);
    max_cnt = 16'd5;
    for (int i = 0; i < 5; i++) step(1'b1);
    chk("R4 at max", pos, 5);
    step(1'b1);
    chk("R4 wrap up max", pos, 0);
    step(1'b0);
    chk("R4 wrap down max", pos, 5);
    max_cnt = 16'hFFFF;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_latency();
    logic [CNT_W-1:0] p0;
    p0 = pos;
    {a, b} = nxt({a, b}, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 no change at 5th edge", pos, p0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 change at 6th edge", pos, p0 + 1'b1);
    settle();
  endtask

  task automatic t_glitch();
    logic [CNT_W-1:0] p0;
    p0 = pos;
    a = ~a;
    repeat (2) @(negedge clk);
    a = ~a;
    settle();
    chk("R5 glitch ignored", pos, p0);
    chk("R5 no error", err, 0);
  endtask

  task automatic t_div();
    logic [CNT_W-1:0] p0;
    div = 4'd3;
    settle();
    p0 = pos;
    a = ~a;
    repeat (8) @(negedge clk);
    a = ~a;
    settle();
    chk("R6 8-cycle pulse ignored at div 3", pos, p0);
    step(1'b1);
    chk("R6 held step counted at div 3", pos, p0 + 1'b1);
    div = '0;
    settle();
  endtask

  task automatic t_err();
    logic [CNT_W-1:0] p0;
    p0 = pos;
    a = ~a; b = ~b;
    settle();
    chk("R8 err set", err, 1);
    chk("R8 count kept", pos, p0);
    repeat (10) @(negedge clk);
    chk("R8 err sticky", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
    chk("R8 err cleared", err, 0);
  endtask

  task automatic t_enable();
    logic [CNT_W-1:0] p0;
    step(1'b0);
    p0 = pos;
    en = 1'b0;
    step(1'b1);
    chk("R12 disabled count", pos, p0);
    chk("R12 disabled dir", dir, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R12 no late count", pos, p0);
    step(1'b1);
    chk("R12 re-enabled count", pos, p0 + 1'b1);
  endtask

  task automatic t_clear();
    {a, b} = nxt({a, b}, 1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    chk("R10 clear beats step", pos, 0);
    settle();
    chk("R10 stays clear", pos, 0);
  endtask

  task automatic t_snap();
    step(1'b0);
    step(1'b0);
    chk("R11 setup", pos, 16'hFFFE);
    snap = 1'b1; @(negedge clk); snap = 1'b0;
    step(1'b1);
    step(1'b1);
    chk("R11 live moved", pos, 0);
    rd_hi = 1'b1; #1;
    chk("R11 hi held", rd_half, 8'hFF);
    rd_hi = 1'b0; #1;
    chk("R11 lo held", rd_half, 8'hFE);
    snap = 1'b1; @(negedge clk); snap = 1'b0;
    rd_hi = 1'b1; #1;
    chk("R11 hi new", rd_half, 8'h00);
    rd_hi = 1'b0; #1;
    chk("R11 lo new", rd_half, 8'h00);
  endtask

  task automatic t_index();
    idx = 1'b1;
    repeat (2) @(negedge clk);
    idx = 1'b0;
    settle();
    chk("R13 index glitch", idx_f, 0);
    idx = 1'b1;
    settle();
    chk("R13 index high", idx_f, 1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_wrap();
    t_latency();
    t_glitch();
    t_div();
    t_err();
    t_enable();
    t_clear();
    t_snap();
    t_index();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule